// File: doc/BRIEF.md
# Run-Time Selectable Probe Capture Controller

This block is the control core of an on-chip logic debugger. It takes a wide bank of 32-bit probe inputs (300 by default) and routes four of them, chosen at run time by index, into a stream of sample words. A host writes the configuration as already-decoded fields: trigger condition and threshold, sample rate code, capture length and mode. It then pulses `start`. The block produces timestamped samples, each carrying all four selected channels, for a downstream packetizer.

A session can begin at once or wait for a trigger. The trigger compares the first selected channel with a threshold. Sample strobes come from a clock divider with 25 rates between 1 MHz and 1 kHz, where the core clock frequency is given in cycles per microsecond. In bounded mode a session ends on its own after a multiple of 1024 samples. In free-running mode it lasts until `stop`.

Top module: `dbg_capture_ctrl`

## Requirements
- R1: In each sample, field c (bits c*32 and up of `smp_data`) holds the probe whose index is on select slot c at the sampling edge. An index of 300 or above gives an all-zero field. Indices may change while a session runs.
- R2: With the trigger disabled, the first sample appears on the clock edge after the edge that samples `start`.
- R3: The trigger compares channel 0 with the threshold as unsigned numbers. The mode codes are 0 (greater), 1 (less), 2 (equal) and 3 (never fires). The other channels have no influence on the trigger.
- R4: While armed, no samples are produced. After the edge that sees the condition true, the block leaves the armed state, and the first sample follows on the next edge.
- R5: Rate code k spaces samples by M(k)*CYC_PER_US cycles. M runs 1,2,3,4,5,6,8,10,12,15,20,25,30,40,50,60,80,100,150,200,250,400,500,750,1000 for codes 0..24. Codes 25..31 use 1000.
- R6: In bounded mode a session produces exactly `len_blocks`*1024 samples. A value of 0 counts as 1 and values above 976 count as 976. `busy` falls on the edge that produces the last sample.
- R7: In free-running mode sampling continues past any length until `stop`, and the sample number wraps at 20 bits.
- R8: `stop` ends an armed or running session on the next edge. No sample is produced from that edge onward.
- R9: `smp_num` is 0 for the first sample of every session and rises by one per sample.
- R10: `start` while a session is active has no effect. Numbering and rate continue unchanged.
- R11: After reset, `busy`, `armed` and `smp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_bus | input | NUM_PROBES*32 | Flattened probe inputs, probe i at bits i*32 |
| sel_idx | input | 4*9 | Four probe indices, slot c at bits c*9 |
| trig_en | input | 1 | Wait for trigger before sampling |
| trig_mode | input | 2 | Trigger condition code |
| trig_value | input | 32 | Trigger threshold |
| rate_code | input | 5 | Sample rate code |
| len_blocks | input | 10 | Capture length in 1024-sample blocks |
| infinite | input | 1 | Free-running mode |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop / abort pulse |
| busy | output | 1 | Session armed or running |
| armed | output | 1 | Waiting for trigger |
| smp_valid | output | 1 | Sample word valid this cycle |
| smp_data | output | 4*32 | Four selected channel values |
| smp_num | output | 20 | Running sample number |

## Verification
On every cycle the assertions check four things. An out-of-range index yields a zero channel. The divider count stays below the active divisor. The sample count never passes the bounded limit. A stop always returns the block to idle. They also check that a sample only follows a cycle with an active session, and that a start during a session leaves the latched rate alone. Only the bench scenarios can show the actual sample values, the exact spacing per rate code and the total length of a bounded session. The same holds for the latency of start and of the trigger, the selectivity of each trigger mode and the numbering restart across sessions.

// File: rtl/dbg_cap_pkg.sv
package dbg_cap_pkg;

   localparam int RATE_CODE_W   = 5;
   localparam int RATE_COUNT    = 25;
   localparam int RATE_MAX_MULT = 1000;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } cap_state_e;

   typedef enum logic [1:0] {
      TRIG_GT  = 2'd0,
      TRIG_LT  = 2'd1,
      TRIG_EQ  = 2'd2,
      TRIG_OFF = 2'd3
   } trig_mode_e;

   // Period multiple of the 1 us base period for each rate code.
   function automatic int unsigned rate_mult(input logic [RATE_CODE_W-1:0] code);
      case (code)
         5'd0:  rate_mult = 1;
         5'd1:  rate_mult = 2;
         5'd2:  rate_mult = 3;
         5'd3:  rate_mult = 4;
         5'd4:  rate_mult = 5;
         5'd5:  rate_mult = 6;
         5'd6:  rate_mult = 8;
         5'd7:  rate_mult = 10;
         5'd8:  rate_mult = 12;
         5'd9:  rate_mult = 15;
         5'd10: rate_mult = 20;
         5'd11: rate_mult = 25;
         5'd12: rate_mult = 30;
         5'd13: rate_mult = 40;
         5'd14: rate_mult = 50;
         5'd15: rate_mult = 60;
         5'd16: rate_mult = 80;
         5'd17: rate_mult = 100;
         5'd18: rate_mult = 150;
         5'd19: rate_mult = 200;
         5'd20: rate_mult = 250;
         5'd21: rate_mult = 400;
         5'd22: rate_mult = 500;
         5'd23: rate_mult = 750;
         default: rate_mult = RATE_MAX_MULT;
      endcase
   endfunction

endpackage

// File: rtl/probe_select.sv
module probe_select #(
   parameter int NUM_PROBES = 300,
   parameter int DATA_W     = 32,
   parameter int SEL_W      = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PROBES*DATA_W-1:0] probes,
   input  logic [SEL_W-1:0]             sel,
   output logic [DATA_W-1:0]            data
);

   localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(NUM_PROBES);

   logic [NUM_PROBES-1:0] hot;
   logic [DATA_W-1:0]     gated [NUM_PROBES];

   // One decoded enable per probe gates its word; an OR tree merges them.
   for (genvar i = 0; i < NUM_PROBES; i++) begin : g_gate
      assign hot[i]   = (sel == SEL_W'(i));
      assign gated[i] = probes[i*DATA_W +: DATA_W] & {DATA_W{hot[i]}};
   end

   always_comb begin
      data = '0;
      for (int i = 0; i < NUM_PROBES; i++) begin
         data = data | gated[i];
      end
   end

   // R1: an index past the probe bank yields an all-zero channel
   assert_oor_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel} >= SEL_LIMIT) |-> (data == '0));

endmodule

// File: rtl/trig_compare.sv
module trig_compare import dbg_cap_pkg::*; #(
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic [DATA_W-1:0] chan,
   input  logic [DATA_W-1:0] thresh,
   input  trig_mode_e        mode,
   output logic              hit
);

   logic gt, lt;

   if (SIGNED_CMP) begin : g_signed
      assign gt = $signed(chan) > $signed(thresh);
      assign lt = $signed(chan) < $signed(thresh);
   end else begin : g_unsigned
      assign gt = chan > thresh;
      assign lt = chan < thresh;
   end

   always_comb begin
      unique case (mode)
         TRIG_GT: hit = gt;
         TRIG_LT: hit = lt;
         TRIG_EQ: hit = (chan == thresh);
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/rate_divider.sv
module rate_divider import dbg_cap_pkg::*; #(
   parameter int CYC_PER_US = 100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic [RATE_CODE_W-1:0] code,
   output logic                   strobe
);

   localparam int MAX_DIV = RATE_MAX_MULT * CYC_PER_US;
   localparam int CNT_W   = $clog2(MAX_DIV + 1);

   logic [CNT_W-1:0] div;
   logic [CNT_W-1:0] cnt;

   assign div    = CNT_W'(rate_mult(code) * CYC_PER_US);
   assign strobe = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt == div - 1'b1) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R5: the phase counter stays within the active divisor
   assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < div));

endmodule

// File: rtl/capture_seq.sv
module capture_seq import dbg_cap_pkg::*; #(
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 10,
   parameter int BLOCK_LOG2 = 10,
   parameter int MAX_BLOCKS = 976,
   parameter int SMP_NUM_W  = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   stop,
   input  logic                   trig_en,
   input  logic [1:0]             mode_in,
   input  logic [DATA_W-1:0]      value_in,
   input  logic [RATE_CODE_W-1:0] rate_in,
   input  logic [LEN_W-1:0]       len_in,
   input  logic                   inf_in,
   input  logic                   trig_hit,
   input  logic                   strobe,
   output cap_state_e             state,
   output trig_mode_e             cfg_mode,
   output logic [DATA_W-1:0]      cfg_value,
   output logic [RATE_CODE_W-1:0] cfg_rate,
   output logic [SMP_NUM_W-1:0]   sc,
   output logic                   take
);

   localparam int LIM_W = LEN_W + BLOCK_LOG2;

   logic [LEN_W-1:0]     blk_eff;
   logic [SMP_NUM_W-1:0] lim_m1;
   logic                 cfg_inf;
   logic                 last;

   always_comb begin
      if (len_in == '0) begin
         blk_eff = LEN_W'(1);
      end else if (len_in > LEN_W'(MAX_BLOCKS)) begin
         blk_eff = LEN_W'(MAX_BLOCKS);
      end else begin
         blk_eff = len_in;
      end
   end

   assign take = (state == ST_RUN) && strobe && !stop;
   assign last = !cfg_inf && (sc == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cfg_mode  <= TRIG_OFF;
         cfg_value <= '0;
         cfg_rate  <= '0;
         cfg_inf   <= 1'b0;
         lim_m1    <= '0;
         sc        <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cfg_mode  <= trig_mode_e'(mode_in);
                  cfg_value <= value_in;
                  cfg_rate  <= rate_in;
                  cfg_inf   <= inf_in;
                  lim_m1    <= SMP_NUM_W'({blk_eff, {BLOCK_LOG2{1'b0}}}) - 1'b1;
                  sc        <= '0;
                  state     <= trig_en ? ST_ARMED : ST_RUN;
               end
            end
            ST_ARMED: begin
               if (stop) begin
                  state <= ST_IDLE;
               end else if (trig_hit) begin
                  state <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (stop) begin
                  state <= ST_IDLE;
                  sc    <= '0;
               end else if (strobe) begin
                  if (last) begin
                     state <= ST_IDLE;
                     sc    <= '0;
                  end else begin
                     sc <= sc + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   if (LIM_W > SMP_NUM_W) begin : g_lim_chk
      if ((MAX_BLOCKS << BLOCK_LOG2) > (1 << SMP_NUM_W)) begin : g_bad_lim
         $error("capture limit does not fit the sample number width");
      end
   end

   // R6: a bounded session never counts past its limit
   assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_RUN) && !cfg_inf) |-> (sc <= lim_m1));

   // R8: stop always returns to idle
   assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state != ST_IDLE) && stop) |=> (state == ST_IDLE));

   // R10: a start during a session leaves the latched rate untouched
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_RUN) && start && !stop) |=> (cfg_rate == $past(cfg_rate)));

endmodule

// File: rtl/dbg_capture_ctrl.sv
module dbg_capture_ctrl import dbg_cap_pkg::*; #(
   parameter int NUM_PROBES = 300,
   parameter int DATA_W     = 32,
   parameter int NUM_CH     = 4,
   parameter int SEL_W      = 9,
   parameter int LEN_W      = 10,
   parameter int BLOCK_LOG2 = 10,
   parameter int MAX_BLOCKS = 976,
   parameter int SMP_NUM_W  = 20,
   parameter int CYC_PER_US = 100,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PROBES*DATA_W-1:0] probe_bus,
   input  logic [NUM_CH*SEL_W-1:0]      sel_idx,
   input  logic                         trig_en,
   input  logic [1:0]                   trig_mode,
   input  logic [DATA_W-1:0]            trig_value,
   input  logic [RATE_CODE_W-1:0]       rate_code,
   input  logic [LEN_W-1:0]             len_blocks,
   input  logic                         infinite,
   input  logic                         start,
   input  logic                         stop,
   output logic                         busy,
   output logic                         armed,
   output logic                         smp_valid,
   output logic [NUM_CH*DATA_W-1:0]     smp_data,
   output logic [SMP_NUM_W-1:0]         smp_num
);

   localparam int SMP_W = NUM_CH * DATA_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("at least one channel is required");
   end
   if ((1 << SEL_W) < NUM_PROBES) begin : g_bad_sel
      $error("select width cannot address every probe");
   end
   if (MAX_BLOCKS >= (1 << LEN_W)) begin : g_bad_len
      $error("length field cannot hold the block limit");
   end
   if (CYC_PER_US < 1) begin : g_bad_clk
      $error("core clock must provide at least one cycle per microsecond");
   end

   logic [DATA_W-1:0]      ch_live [NUM_CH];
   logic [SMP_W-1:0]       smp_next;
   cap_state_e             state;
   trig_mode_e             cfg_mode;
   logic [DATA_W-1:0]      cfg_value;
   logic [RATE_CODE_W-1:0] cfg_rate;
   logic [SMP_NUM_W-1:0]   sc;
   logic                   take;
   logic                   trig_hit;
   logic                   strobe;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      probe_select #(
         .NUM_PROBES (NUM_PROBES),
         .DATA_W     (DATA_W),
         .SEL_W      (SEL_W)
      ) u_sel (
         .clk    (clk),
         .rst_n  (rst_n),
         .probes (probe_bus),
         .sel    (sel_idx[c*SEL_W +: SEL_W]),
         .data   (ch_live[c])
      );
      assign smp_next[c*DATA_W +: DATA_W] = ch_live[c];
   end

   trig_compare #(
      .DATA_W     (DATA_W),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_trig (
      .chan   (ch_live[0]),
      .thresh (cfg_value),
      .mode   (cfg_mode),
      .hit    (trig_hit)
   );

   rate_divider #(
      .CYC_PER_US (CYC_PER_US)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_RUN),
      .code   (cfg_rate),
      .strobe (strobe)
   );

   capture_seq #(
      .DATA_W     (DATA_W),
      .LEN_W      (LEN_W),
      .BLOCK_LOG2 (BLOCK_LOG2),
      .MAX_BLOCKS (MAX_BLOCKS),
      .SMP_NUM_W  (SMP_NUM_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .trig_en   (trig_en),
      .mode_in   (trig_mode),
      .value_in  (trig_value),
      .rate_in   (rate_code),
      .len_in    (len_blocks),
      .inf_in    (infinite),
      .trig_hit  (trig_hit),
      .strobe    (strobe),
      .state     (state),
      .cfg_mode  (cfg_mode),
      .cfg_value (cfg_value),
      .cfg_rate  (cfg_rate),
      .sc        (sc),
      .take      (take)
   );

   assign busy  = (state != ST_IDLE);
   assign armed = (state == ST_ARMED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_data  <= '0;
         smp_num   <= '0;
      end else begin
         smp_valid <= take;
         if (take) begin
            smp_data <= smp_next;
            smp_num  <= sc;
         end
      end
   end

   // R4: a sample only follows a cycle with an active session
   assert_valid_in_session_R4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> $past(busy));

endmodule

// File: tb/test_dbg_capture_ctrl.sv
`timescale 1ns/1ps
module test_dbg_capture_ctrl;

   localparam int NP  = 300;
   localparam int CPU = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   pv [NP];
   logic [8:0]    sel [4];
   logic [NP*32-1:0] probe_bus;
   logic [35:0]   sel_idx;
   logic          trig_en = 1'b0;
   logic [1:0]    trig_mode = 2'd3;
   logic [31:0]   trig_value = '0;
   logic [4:0]    rate_code = '0;
   logic [9:0]    len_blocks = 10'd1;
   logic          infinite = 1'b0;
   logic          start = 1'b0;
   logic          stop = 1'b0;
   logic          busy, armed, smp_valid;
   logic [127:0]  smp_data;
   logic [19:0]   smp_num;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NP; i++) probe_bus[i*32 +: 32] = pv[i];
      for (int c = 0; c < 4; c++) sel_idx[c*9 +: 9] = sel[c];
   end

   dbg_capture_ctrl #(.CYC_PER_US(CPU)) i_dbg_capture_ctrl (
      .clk(clk), .rst_n(rst_n), .probe_bus(probe_bus), .sel_idx(sel_idx),
      .trig_en(trig_en), .trig_mode(trig_mode), .trig_value(trig_value),
      .rate_code(rate_code), .len_blocks(len_blocks), .infinite(infinite),
      .start(start), .stop(stop), .busy(busy), .armed(armed),
      .smp_valid(smp_valid), .smp_data(smp_data), .smp_num(smp_num));

   function automatic int mult_of(input int code);
      int t [25] = '{1,2,3,4,5,6,8,10,12,15,20,25,30,40,50,60,80,100,150,200,250,400,500,750,1000};
      return (code < 25) ? t[code] : 1000;
   endfunction

   function automatic logic [127:0] exp_vec();
      logic [127:0] v;
      for (int c = 0; c < 4; c++) v[c*32 +: 32] = (sel[c] < 9'(NP)) ? pv[sel[c]] : 32'd0;
      return v;
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_start();
      tick(); start = 1'b1;
      tick(); start = 1'b0;
   endtask

   task automatic do_stop();
      tick(); stop = 1'b1;
      tick(); stop = 1'b0;
      check("R8 busy after stop", 128'(busy), 128'd0);
      for (int k = 0; k < 20; k++) begin
         tick();
         check("R8 no sample after stop", 128'(smp_valid), 128'd0);
      end
   endtask

   // Bounded session started just before: checks data, numbering, spacing, length.
   task automatic run_bounded(input int exp_total, input int gap, input string tag);
      int got = 0;
      int last_t = 0;
      for (int t = 1; t < exp_total * gap + 50; t++) begin
         tick();
         if (smp_valid) begin
            if (got == 0) check({tag, " R2 first sample latency"}, 128'(t), 128'd1);
            else check({tag, " R5 spacing"}, 128'(t - last_t), 128'(gap));
            check({tag, " R9 number"}, 128'(smp_num), 128'(got));
            check({tag, " R1 data"}, smp_data, exp_vec());
            last_t = t;
            got++;
            if (($urandom % 8) == 0) sel[$urandom % 4] = 9'($urandom_range(0, 511));
            if (($urandom % 4) == 0) pv[$urandom % NP] = $urandom;
         end
         if (!busy) break;
      end
      check({tag, " R6 total samples"}, 128'(got), 128'(exp_total));
      check({tag, " R6 idle at end"}, 128'(busy), 128'd0);
   endtask

   task automatic gap_test(input int code);
      int t0 = 0;
      int seen = 0;
      rate_code = 5'(code); infinite = 1'b1; trig_en = 1'b0;
      pulse_start();
      for (int t = 1; t < 3 * 1000 * CPU + 20 && seen < 3; t++) begin
         tick();
         if (smp_valid) begin
            if (seen > 0) check($sformatf("R5 gap code %0d", code), 128'(t - t0), 128'(mult_of(code) * CPU));
            t0 = t;
            seen++;
         end
      end
      check($sformatf("R5 samples seen code %0d", code), 128'(seen), 128'd3);
      do_stop();
   endtask

   task automatic trig_test(input logic [1:0] mode, input logic [31:0] thr,
                            input logic [31:0] bad, input logic [31:0] good, input string tag);
      sel[0] = 9'd7; pv[7] = bad; sel[1] = 9'd8; pv[8] = good;
      trig_value = thr; trig_mode = mode; trig_en = 1'b1;
      infinite = 1'b1; rate_code = '0;
      pulse_start();
      for (int k = 0; k < 10; k++) begin
         check({tag, " R4 stays armed"}, 128'(armed), 128'd1);
         check({tag, " R4 no sample while armed"}, 128'(smp_valid), 128'd0);
         tick();
      end
      pv[7] = good;
      tick();
      check({tag, " R4 left armed"}, 128'({armed, busy, smp_valid}), 128'b010);
      tick();
      check({tag, " R3 first sample after trigger"}, 128'(smp_valid), 128'd1);
      check({tag, " R9 number after trigger"}, 128'(smp_num), 128'd0);
      check({tag, " R1 trigger channel data"}, 128'(smp_data[31:0]), 128'(good));
      do_stop();
      trig_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd8675309));
      for (int i = 0; i < NP; i++) pv[i] = $urandom;
      sel[0] = 9'd299; sel[1] = 9'd0; sel[2] = 9'd150; sel[3] = 9'd300;
      repeat (3) tick();
      check("R11 reset state", 128'({busy, armed, smp_valid}), 128'd0);
      rst_n = 1'b1;
      tick();
      check("R11 idle after reset", 128'({busy, armed, smp_valid}), 128'd0);

      // Bounded session, fastest rate, boundary selects then random run-time changes
      rate_code = 5'd0; len_blocks = 10'd1; infinite = 1'b0;
      pulse_start();
      run_bounded(1024, CPU, "len1");

      // Length 0 counts as one block, rate code 1
      for (int c = 0; c < 4; c++) sel[c] = 9'($urandom_range(0, 511));
      rate_code = 5'd1; len_blocks = 10'd0;
      pulse_start();
      run_bounded(1024, 2 * CPU, "len0");

      // Rates: random low codes plus the slow end and the clamped codes
      gap_test(int'($urandom_range(2, 12)));
      gap_test(13);
      gap_test(24);
      gap_test(31);

      // Free-running past a block, with an ignored start in the middle
      rate_code = 5'd0; len_blocks = 10'd1; infinite = 1'b1;
      pulse_start();
      begin
         int got = 0;
         int last_t = 0;
         for (int t = 1; t < 4000 && got < 1100; t++) begin
            tick();
            if (start) start = 1'b0;
            if (smp_valid) begin
               if (got > 0) check("R10 spacing kept", 128'(t - last_t), 128'(CPU));
               check("R7 number continues", 128'(smp_num), 128'(got));
               last_t = t;
               got++;
               if (got == 50) begin
                  rate_code = 5'd31; trig_en = 1'b1; start = 1'b1;
               end
            end
         end
         check("R7 still running past length", 128'(busy), 128'd1);
         check("R7 sample count", 128'(got), 128'd1100);
         trig_en = 1'b0;
      end
      do_stop();

      // Numbering restarts in a new session
      rate_code = 5'd0; infinite = 1'b1;
      pulse_start();
      tick();
      check("R9 restart number", 128'({smp_valid, smp_num}), 128'({1'b1, 20'd0}));
      do_stop();

      // Trigger conditions on channel 0, unsigned
      trig_test(2'd0, 32'd1,    32'd1,    32'h8000_0000, "gt");
      trig_test(2'd1, 32'd1000, 32'd1000, 32'd999,       "lt");
      trig_test(2'd2, 32'd1000, 32'd5,    32'd1000,      "eq");

      // Mode 3 never fires
      sel[0] = 9'd7; pv[7] = 32'd0; trig_mode = 2'd3; trig_value = 32'd0; trig_en = 1'b1;
      pulse_start();
      for (int k = 0; k < 30; k++) begin
         tick();
         pv[7] = $urandom;
         if (k == 29) check("R3 mode 3 never fires", 128'({armed, smp_valid}), 128'b10);
      end
      do_stop();
      trig_en = 1'b0;

      if (!finished) begin
         finished = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule